// File: doc/BRIEF.md
# Carrier Column Tracker with Sensorless Homing

This block keeps track of which character column a print carrier sits at. The only feedback is a slotted wheel that turns with the carrier, read by a light and phototransistor. Each slot that passes gives one pulse. The pulse is brought into the clock domain and counted: up while the carrier moves right, down while it moves left. Whichever unit drives the motor reports the direction of motion. The count divided by a fixed number of pulses per column gives the column.

There is no home switch. After reset the block asks for slow leftward travel until the wheel has been silent for a programmable number of clock cycles. The default is 100 ms at 125 MHz. That silence means the carrier is resting against its left stop. The block then asks for rightward travel for a fixed number of pulses and defines the spot where it stops as column 0. From then on it tracks motion and reports a homed flag. A separate, shorter silence window drives a carrier-stopped flag that the print logic can use to know when motion has settled.

Top module: `carrierTracker`

## Requirements
- R1: While reset is held and in the first cycle after release, motorLeft is 1, motorRight is 0, homed is 0, column is 0 and stopped is 0.
- R2: A rising edge on sensorRaw is counted exactly once, however long the input stays high. Its effect on column is visible after the third rising clock edge that follows the input change.
- R3: After reset, motorLeft stays asserted until HOME_QUIET_CYC clock cycles have passed with no detected pulse. Any pulse restarts that wait.
- R4: When the homing silence ends, motorLeft drops and motorRight is asserted. motorRight holds until BACKOFF_PULSES pulses have been counted.
- R5: Once the back-off pulses are counted, both motor requests drop, the position becomes 0 and homed rises. homed then stays 1 until the next reset.
- R6: Once homed, each pulse adds one to the position when dirRight is 1 and subtracts one when it is 0. column is the position divided by PULSES_PER_COL, rounded down.
- R7: The position saturates: it never goes below 0 and never goes above MAX_COLS*PULSES_PER_COL-1.
- R8: stopped is 1 exactly when at least STOP_QUIET_CYC cycles have passed since the last detected pulse. It returns to 0 one cycle after a pulse is detected.
- R9: Pulses that arrive before homed rises never change column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sensorRaw | input | 1 | Unsynchronised slotted-wheel sensor output |
| dirRight | input | 1 | Current travel direction, 1 = rightward |
| motorLeft | output | 1 | Request for slow leftward travel (homing seek) |
| motorRight | output | 1 | Request for rightward travel (homing back-off) |
| column | output | $clog2(MAX_COLS) | Current character column |
| homed | output | 1 | Column 0 has been established |
| stopped | output | 1 | No pulse for STOP_QUIET_CYC cycles |

## Verification
A corrupt position register appears on column as soon as its wrong value crosses a column boundary. The bench compares every cycle, so a drift shows within at most PULSES_PER_COL pulses. The same applies to a synchroniser that double-counts a long pulse. A silence counter that fails to restart moves the motor-request handover or the stopped flag, and the mismatch appears on the very cycle the outputs differ from a behavioural model. The model counts cycles since the last edge independently. An error in the homing sequence shows within one cycle of the expected transition, as a motor request or homed at the wrong level.

// File: rtl/carrierTrackPkg.sv
package carrierTrackPkg;
  typedef enum logic [1:0] {
    SEEK_LEFT = 2'd0,
    BACK_OFF  = 2'd1,
    TRACKING  = 2'd2
  } homeStateT;

  // strobes from control into the datapath
  typedef struct packed {
    logic clearBackoff;
    logic clearPos;
    logic trackEn;
  } trackStrobeT;
endpackage

// File: rtl/carrierTrackDatapath.sv
module carrierTrackDatapath
  import carrierTrackPkg::*;
#(
  parameter int PULSES_PER_COL = 4,
  parameter int MAX_COLS       = 132,
  parameter int BACKOFF_PULSES = 6,
  parameter int HOME_QUIET_CYC = 12_500_000,
  parameter int STOP_QUIET_CYC = 125_000,
  localparam int POS_MAX = MAX_COLS * PULSES_PER_COL - 1,
  localparam int PW      = $clog2(POS_MAX + 1),
  localparam int COL_W   = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1,
  localparam int QMAX    = (HOME_QUIET_CYC > STOP_QUIET_CYC) ? HOME_QUIET_CYC : STOP_QUIET_CYC,
  localparam int QW      = $clog2(QMAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sensorRaw,
  input  logic             dirRight,
  input  trackStrobeT      strobe,
  output logic             pulseEdge,
  output logic             homeQuiet,
  output logic             backoffDone,
  output logic [COL_W-1:0] column,
  output logic             stopped
);
  logic [2:0]    syncQ;
  logic [QW-1:0] quietCnt;
  logic [PW-1:0] posCnt;

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], sensorRaw};
  end
  assign pulseEdge = syncQ[1] & ~syncQ[2];

  // cycles since the last detected pulse, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       quietCnt <= '0;
    else if (pulseEdge)              quietCnt <= '0;
    else if (quietCnt != QW'(QMAX))  quietCnt <= quietCnt + 1'b1;
  end
  assign homeQuiet = (quietCnt >= QW'(HOME_QUIET_CYC));
  assign stopped   = (quietCnt >= QW'(STOP_QUIET_CYC));

  // back-off pulse counter; a zero distance needs no counter at all
  generate
    if (BACKOFF_PULSES == 0) begin : gNoBackoff
      assign backoffDone = 1'b1;
    end else begin : gBackoff
      localparam int BW = $clog2(BACKOFF_PULSES + 1);
      logic [BW-1:0] backCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                          backCnt <= '0;
        else if (strobe.clearBackoff)                       backCnt <= '0;
        else if (pulseEdge && backCnt != BW'(BACKOFF_PULSES)) backCnt <= backCnt + 1'b1;
      end
      assign backoffDone = (backCnt == BW'(BACKOFF_PULSES));
    end
  endgenerate

  // signed travel in pulses, clamped to the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 posCnt <= '0;
    else if (strobe.clearPos)  posCnt <= '0;
    else if (strobe.trackEn && pulseEdge) begin
      if (dirRight) begin
        if (posCnt != PW'(POS_MAX)) posCnt <= posCnt + 1'b1;
      end else begin
        if (posCnt != '0) posCnt <= posCnt - 1'b1;
      end
    end
  end
  assign column = COL_W'(posCnt / PW'(PULSES_PER_COL));

  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    pulseEdge |=> !pulseEdge);
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearPos |=> posCnt == '0);
  a_r6_step_right: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.trackEn && pulseEdge && dirRight && posCnt != PW'(POS_MAX))
      |=> posCnt == $past(posCnt) + 1'b1);
  a_r7_upper_bound: assert property (@(posedge clk) disable iff (!rstN)
    posCnt <= PW'(POS_MAX));
  a_r9_hold_unhomed: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.trackEn && !strobe.clearPos) |=> $stable(posCnt));
endmodule

// File: rtl/carrierTrackControl.sv
module carrierTrackControl
  import carrierTrackPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        homeQuiet,
  input  logic        backoffDone,
  output trackStrobeT strobe,
  output logic        motorLeft,
  output logic        motorRight,
  output logic        homed
);
  homeStateT state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEEK_LEFT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      SEEK_LEFT: if (homeQuiet) begin
        stateNext           = BACK_OFF;
        strobe.clearBackoff = 1'b1;
      end
      BACK_OFF: if (backoffDone) begin
        stateNext       = TRACKING;
        strobe.clearPos = 1'b1;
      end
      TRACKING: strobe.trackEn = 1'b1;
      default:  stateNext = SEEK_LEFT;
    endcase
  end

  assign motorLeft  = (state == SEEK_LEFT);
  assign motorRight = (state == BACK_OFF);
  assign homed      = (state == TRACKING);

  a_r5_homed_sticky: assert property (@(posedge clk) disable iff (!rstN)
    homed |=> homed);
  a_r4_right_follows_left: assert property (@(posedge clk) disable iff (!rstN)
    $rose(motorRight) |-> $past(motorLeft));
  a_r5_homed_after_backoff: assert property (@(posedge clk) disable iff (!rstN)
    $rose(homed) |-> $past(motorRight) && $past(backoffDone));
  a_r4_motors_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({motorLeft, motorRight, homed}));
endmodule

// File: rtl/carrierTracker.sv
module carrierTracker
  import carrierTrackPkg::*;
#(
  parameter int PULSES_PER_COL = 4,
  parameter int MAX_COLS       = 132,
  parameter int BACKOFF_PULSES = 6,
  parameter int HOME_QUIET_CYC = 12_500_000,
  parameter int STOP_QUIET_CYC = 125_000,
  localparam int COL_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sensorRaw,
  input  logic             dirRight,
  output logic             motorLeft,
  output logic             motorRight,
  output logic [COL_W-1:0] column,
  output logic             homed,
  output logic             stopped
);
  trackStrobeT strobe;
  logic        pulseEdge, homeQuiet, backoffDone;

  carrierTrackDatapath #(
    .PULSES_PER_COL(PULSES_PER_COL),
    .MAX_COLS      (MAX_COLS),
    .BACKOFF_PULSES(BACKOFF_PULSES),
    .HOME_QUIET_CYC(HOME_QUIET_CYC),
    .STOP_QUIET_CYC(STOP_QUIET_CYC)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .sensorRaw  (sensorRaw),
    .dirRight   (dirRight),
    .strobe     (strobe),
    .pulseEdge  (pulseEdge),
    .homeQuiet  (homeQuiet),
    .backoffDone(backoffDone),
    .column     (column),
    .stopped    (stopped)
  );

  carrierTrackControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .homeQuiet  (homeQuiet),
    .backoffDone(backoffDone),
    .strobe     (strobe),
    .motorLeft  (motorLeft),
    .motorRight (motorRight),
    .homed      (homed)
  );

  a_r9_column_zero_unhomed: assert property (@(posedge clk) disable iff (!rstN)
    !homed |-> column == '0);
endmodule

// File: tb/sim_carrierTracker.sv
`timescale 1ns/1ps
module sim_carrierTracker;
  localparam int PPC = 4, MAXC = 8, BO = 3, HOMEQ = 40, STOPQ = 10;
  localparam int POSMAX = MAXC * PPC - 1;

  logic clk = 1'b0, rstN = 1'b0, sensorRaw = 1'b0, dirRight = 1'b0;
  logic motorLeft, motorRight, homed, stopped;
  logic [2:0] column;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  carrierTracker #(.PULSES_PER_COL(PPC), .MAX_COLS(MAXC), .BACKOFF_PULSES(BO),
    .HOME_QUIET_CYC(HOMEQ), .STOP_QUIET_CYC(STOPQ)) u0 (
    .clk(clk), .rstN(rstN), .sensorRaw(sensorRaw), .dirRight(dirRight),
    .motorLeft(motorLeft), .motorRight(motorRight), .column(column),
    .homed(homed), .stopped(stopped));

  // behavioural reference: raw history, phase, silence length, pulse tally
  int mPhase, mQuiet, mBack, mPos;
  bit r1, r2, r3, e;
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mQuiet = 0; mBack = 0; mPos = 0; r1 = 0; r2 = 0; r3 = 0;
    end else begin
      e = r2 && !r3;
      if (mPhase == 0) begin
        if (mQuiet >= HOMEQ) begin mPhase = 1; mBack = 0; end
      end else if (mPhase == 1) begin
        if (mBack >= BO) begin mPhase = 2; mPos = 0; end
        else if (e) mBack++;
      end else if (e) begin
        if (dirRight) begin if (mPos < POSMAX) mPos++; end
        else if (mPos > 0) mPos--;
      end
      mQuiet = e ? 0 : ((mQuiet < 1000) ? mQuiet + 1 : mQuiet);
      r3 = r2; r2 = r1; r1 = sensorRaw;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    check("R3/R4 motorLeft", motorLeft, mPhase == 0);
    check("R4 motorRight", motorRight, mPhase == 1);
    check("R5 homed", homed, mPhase == 2);
    check("R6/R7 column", column, mPos / PPC);
    check("R8 stopped", stopped, mQuiet >= STOPQ);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(int n, bit right, int highLen);
    dirRight = right;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sensorRaw = 1'b1;
      idle(highLen);
      sensorRaw = 1'b0;
      idle(3);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    idle(3);
    @(negedge clk) rstN = 1'b1;
    check("R1 motorLeft", motorLeft, 1);
    check("R1 motorRight", motorRight, 0);
    check("R1 homed", homed, 0);
    check("R1 column", column, 0);
    check("R1 stopped", stopped, 0);
    pulses(5, 1'b1, 2);   // wheel still turning during the seek
    idle(4);
    check("R3 still seeking", motorLeft, 1);
    check("R9 column while seeking", column, 0);
    idle(50);
    check("R4 back-off started", motorRight, 1);
    check("R4 left released", motorLeft, 0);
    pulses(2, 1'b0, 2);
    idle(4);
    check("R4 back-off holds", motorRight, 1);
    check("R9 column during back-off", column, 0);
    pulses(1, 1'b0, 2);
    idle(6);
    check("R5 homed", homed, 1);
    check("R5 motors idle", motorLeft | motorRight, 0);
    check("R5 column zero", column, 0);
    pulses(9, 1'b1, 2); idle(4);
    check("R6 right 9 pulses", column, 2);
    check("R8 moving not stopped", stopped, 0);
    pulses(3, 1'b0, 2); idle(4);
    check("R6 left 3 pulses", column, 1);
    pulses(10, 1'b0, 2); idle(4);
    check("R7 floor at zero", column, 0);
    pulses(40, 1'b1, 2); idle(4);
    check("R7 ceiling", column, 7);
    pulses(3, 1'b0, 2); idle(4);
    check("R7 leave ceiling", column, 7);
    pulses(1, 1'b0, 20); idle(4);
    check("R2 long pulse counted once", column, 6);
    idle(15);
    check("R8 stopped after silence", stopped, 1);
    pulses(1, 1'b1, 2);
    check("R8 cleared after pulse", stopped, 0);
    check("R5 homed sticky", homed, 1);
    idle(5);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule